// File: doc/BRIEF.md
# DRAM Address Multiplexer and Strobe Steering

This block sits between a memory request source and a bank of DRAM devices. It takes a row address, a column address, a bank number, four per-group column-strobe enables and a write flag. It then drives one shared, time-multiplexed address bus together with four row-strobe groups, four column-strobe groups and a write strobe. An access starts when a request is raised. In the first cycle the row goes onto the bus with the selected row strobes low. The bus then switches to the column, and one cycle later the column strobes fall. The column strobes stay low for as long as the request is held.

While the access is held in its column phase, a column-increment input steps the latched column by one, which serves page bursts. The column enables can be toggled to pulse individual byte lanes. A refresh-in-progress input overrides the bus with a supplied refresh row and freezes the column counter.

A low-active configuration-load input samples the address and bank pins into a small programming register. That register holds three settings: how the bank bits map onto strobe groups, a remap of the bank number, and whether writes delay their column strobe by one cycle.

Top module: `dram_addr_steer`

## Requirements
- R1: After a request is sampled in idle, the next cycle shows the row on `dram_addr` with the selected `ras_n` groups low and all `cas_n` high. The cycle after that shows the column, still with `cas_n` high. The column strobes fall in the cycle after that.
- R2: In every cycle that follows an edge at which `rfsh_active` was high, `dram_addr` equals the `rfsh_row` sampled at that edge. A request sampled in idle while `rfsh_active` is high does not start an access.
- R3: At each edge where `cfg_load_n` is low, `row_in[1:0]` loads the map mode, `col_in[COL_W-2]` loads the write-delay flag and `bank_in` loads the bank remap. `row_in[ROW_W-1]` and `col_in[COL_W-1]` have no effect. No access starts while the load is low.
- R4: The group index is `bank_in XOR remap`. Map mode 00 selects all groups. Mode 01 selects the lower half of the groups when the top index bit is 0 and the upper half when it is 1. Modes 10 and 11 select the single group equal to the index. Reset sets mode 00, remap 0 and delay 0.
- R5: During the column phase, `cas_n[g]` is low only when group g is selected and `cas_en[g]` was high at the previous edge.
- R6: An edge in the column phase with `acc_req`, `col_inc` high and `rfsh_active` low adds one to the column on the bus, modulo 2^COL_W and with no carry into the row. With `rfsh_active` high the column is left unchanged.
- R7: With the delay flag set, a write access keeps `cas_n` high for one extra cycle after the column appears. A read is not delayed.
- R8: After reset, and whenever no access is active, all `ras_n` and `cas_n` bits and `we_n` are high. Without refresh, `dram_addr` holds its last value; after reset it is 0.
- R9: `we_n` is low for the whole of a write access, from the row cycle to the last column cycle, and high for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load_n | input | 1 | Configuration load, active low |
| row_in | input | ROW_W | Row address / configuration bits |
| col_in | input | COL_W | Column address / configuration bits |
| bank_in | input | BANK_W | Bank number / remap bits |
| cas_en | input | 2**BANK_W | Per-group column-strobe enables, active high |
| wr_in | input | 1 | Write access when high |
| acc_req | input | 1 | Access request, held for the whole access |
| col_inc | input | 1 | Column increment |
| rfsh_active | input | 1 | Refresh in progress |
| rfsh_row | input | ROW_W | Refresh row address |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| ras_n | output | 2**BANK_W | Row strobes, active low |
| cas_n | output | 2**BANK_W | Column strobes, active low |
| we_n | output | 1 | Write strobe, active low |

## Verification
Some rules are checked on every cycle. Any column strobe must lie inside the row strobe of the same group. A column strobe must have a row strobe in the cycle before it, and a disabled lane must never carry a column strobe. The refresh row must win the bus, the bus must hold while idle, no access may start during a configuration load, and the write strobe must only appear inside an access. Other rules depend on the exact stimulus, and only the bench scenarios can show them. These are the cycle placement of row, column and strobe, the group chosen by each map mode and remap, the one-cycle write delay and its absence on reads, the exclusion of the top address bits from the load, and column wrap-around with the counter frozen under refresh.

// File: rtl/dstr_pkg.sv
package dstr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ROW  = 3'd1,
      ST_COL  = 3'd2,
      ST_WAIT = 3'd3,
      ST_CAS  = 3'd4
   } dstr_state_e;

   localparam logic [1:0] MAP_ALL  = 2'b00;
   localparam logic [1:0] MAP_PAIR = 2'b01;

endpackage

// File: rtl/dstr_cfg.sv
module dstr_cfg #(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic [1:0]        mode_in,
   input  logic              dly_in,
   input  logic [BANK_W-1:0] remap_in,
   output logic [1:0]        mode_q,
   output logic              dly_q,
   output logic [BANK_W-1:0] remap_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         dly_q   <= 1'b0;
         remap_q <= '0;
      end else if (!load_n) begin
         mode_q  <= mode_in;
         dly_q   <= dly_in;
         remap_q <= remap_in;
      end
   end

endmodule

// File: rtl/dstr_colctr.sv
module dstr_colctr #(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             inc_en,
   input  logic [COL_W-1:0] col_in,
   output logic [COL_W-1:0] col_nxt
);

   logic [COL_W-1:0] col_q;

   always_comb begin
      if (start)
         col_nxt = col_in;
      else if (inc_en)
         col_nxt = col_q + COL_W'(1);
      else
         col_nxt = col_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) col_q <= '0;
      else        col_q <= col_nxt;
   end

endmodule

// File: rtl/dstr_seq.sv
module dstr_seq
   import dstr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_req,
   input  logic        load_n,
   input  logic        rfsh,
   input  logic        wr_in,
   input  logic        dly_en,
   output dstr_state_e st_q,
   output dstr_state_e st_nxt,
   output logic        start,
   output logic        wr_nxt
);

   logic wr_q;

   assign start  = (st_q == ST_IDLE) && acc_req && load_n && !rfsh;
   assign wr_nxt = start ? wr_in : wr_q;

   always_comb begin
      st_nxt = ST_IDLE;
      unique case (st_q)
         ST_IDLE: st_nxt = start ? ST_ROW : ST_IDLE;
         ST_ROW:  st_nxt = acc_req ? ST_COL : ST_IDLE;
         ST_COL:  begin
            if (!acc_req)             st_nxt = ST_IDLE;
            else if (dly_en && wr_q)  st_nxt = ST_WAIT;
            else                      st_nxt = ST_CAS;
         end
         ST_WAIT: st_nxt = acc_req ? ST_CAS : ST_IDLE;
         ST_CAS:  st_nxt = acc_req ? ST_CAS : ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         wr_q <= 1'b0;
      end else begin
         st_q <= st_nxt;
         wr_q <= wr_nxt;
      end
   end

endmodule

// File: rtl/dram_addr_steer.sv
module dram_addr_steer
   import dstr_pkg::*;
#(
   parameter  int ROW_W  = 10,
   parameter  int COL_W  = 10,
   parameter  int BANK_W = 2,
   localparam int NGRP   = 1 << BANK_W,
   localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load_n,
   input  logic [ROW_W-1:0]  row_in,
   input  logic [COL_W-1:0]  col_in,
   input  logic [BANK_W-1:0] bank_in,
   input  logic [NGRP-1:0]   cas_en,
   input  logic              wr_in,
   input  logic              acc_req,
   input  logic              col_inc,
   input  logic              rfsh_active,
   input  logic [ROW_W-1:0]  rfsh_row,
   output logic [AW-1:0]     dram_addr,
   output logic [NGRP-1:0]   ras_n,
   output logic [NGRP-1:0]   cas_n,
   output logic              we_n
);

   if (ROW_W < 3) begin : g_bad_row
      $error("dram_addr_steer: ROW_W must be at least 3");
   end
   if (COL_W < 3) begin : g_bad_col
      $error("dram_addr_steer: COL_W must be at least 3");
   end
   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
      $error("dram_addr_steer: BANK_W must be 1..4");
   end

   logic [1:0]        map_mode;
   logic              wdly;
   logic [BANK_W-1:0] remap;
   dstr_state_e       st_q, st_nxt;
   logic              start, wr_nxt, inc_en;
   logic [COL_W-1:0]  col_nxt;
   logic [BANK_W-1:0] bank_q, bank_nxt, grp_idx;
   logic [NGRP-1:0]   grp_sel;
   logic              active, cas_on;

   dstr_cfg #(.BANK_W(BANK_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_n   (cfg_load_n),
      .mode_in  (row_in[1:0]),
      .dly_in   (col_in[COL_W-2]),
      .remap_in (bank_in),
      .mode_q   (map_mode),
      .dly_q    (wdly),
      .remap_q  (remap)
   );

   dstr_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_req (acc_req),
      .load_n  (cfg_load_n),
      .rfsh    (rfsh_active),
      .wr_in   (wr_in),
      .dly_en  (wdly),
      .st_q    (st_q),
      .st_nxt  (st_nxt),
      .start   (start),
      .wr_nxt  (wr_nxt)
   );

   assign inc_en = (st_q == ST_CAS) && (st_nxt == ST_CAS) && col_inc && !rfsh_active;

   dstr_colctr #(.COL_W(COL_W)) u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .inc_en  (inc_en),
      .col_in  (col_in),
      .col_nxt (col_nxt)
   );

   assign bank_nxt = start ? bank_in : bank_q;
   assign grp_idx  = bank_nxt ^ remap;
   assign active   = (st_nxt != ST_IDLE);
   assign cas_on   = (st_nxt == ST_CAS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q <= '0;
      else        bank_q <= bank_nxt;
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam logic UPPER = (g >= NGRP / 2);

      assign grp_sel[g] = (map_mode == MAP_ALL)
                        | ((map_mode == MAP_PAIR) & (grp_idx[BANK_W-1] == UPPER))
                        | (map_mode[1] & (grp_idx == BANK_W'(g)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ras_n[g] <= 1'b1;
            cas_n[g] <= 1'b1;
         end else begin
            ras_n[g] <= !(active & grp_sel[g]);
            cas_n[g] <= !(cas_on & grp_sel[g] & cas_en[g]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dram_addr <= '0;
         we_n      <= 1'b1;
      end else begin
         we_n <= !(active & wr_nxt);
         if (rfsh_active)
            dram_addr <= AW'(rfsh_row);
         else if (st_nxt == ST_ROW)
            dram_addr <= AW'(row_in);
         else if (active)
            dram_addr <= AW'(col_nxt);
      end
   end

endmodule

// File: rtl/dstr_chk.sv
module dstr_chk #(
   parameter  int ROW_W  = 10,
   parameter  int COL_W  = 10,
   parameter  int BANK_W = 2,
   localparam int NGRP   = 1 << BANK_W,
   localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_load_n,
   input logic [NGRP-1:0]   cas_en,
   input logic              rfsh_active,
   input logic [ROW_W-1:0]  rfsh_row,
   input logic [AW-1:0]     dram_addr,
   input logic [NGRP-1:0]   ras_n,
   input logic [NGRP-1:0]   cas_n,
   input logic              we_n
);

   AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      ((~cas_n) & ras_n) == '0); // R4

   AST_RAS_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n != '1) |-> ($past(rst_n) && $past(ras_n) != '1)); // R1

   AST_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (((~cas_n) & ~$past(cas_en)) == '0)); // R5

   AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rfsh_active)) |-> (dram_addr == AW'($past(rfsh_row)))); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (ras_n == '1) && !$past(rfsh_active)) |-> $stable(dram_addr)); // R8

   AST_NO_START_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load_n && (ras_n == '1)) |=> (ras_n == '1)); // R3

   AST_WE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (ras_n != '1)); // R9

endmodule

bind dram_addr_steer dstr_chk #(
   .ROW_W  (ROW_W),
   .COL_W  (COL_W),
   .BANK_W (BANK_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_load_n  (cfg_load_n),
   .cas_en      (cas_en),
   .rfsh_active (rfsh_active),
   .rfsh_row    (rfsh_row),
   .dram_addr   (dram_addr),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n)
);

// File: tb/tb_dram_addr_steer.sv
`timescale 1ns/1ps
module tb_dram_addr_steer;

   localparam int RW = 10;
   localparam int CW = 10;
   localparam int BW = 2;
   localparam int NG = 4;

   typedef struct {
      logic [NG-1:0] ras;
      logic [NG-1:0] cas;
      logic [RW-1:0] addr;
      logic          we;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_load_n = 1'b1;
   logic [RW-1:0] row_in = '0;
   logic [CW-1:0] col_in = '0;
   logic [BW-1:0] bank_in = '0;
   logic [NG-1:0] cas_en = '0;
   logic          wr_in = 1'b0;
   logic          acc_req = 1'b0;
   logic          col_inc = 1'b0;
   logic          rfsh_active = 1'b0;
   logic [RW-1:0] rfsh_row = '0;
   logic [RW-1:0] dram_addr;
   logic [NG-1:0] ras_n, cas_n;
   logic          we_n;

   int   total = 0;
   int   bad = 0;
   exp_t sb[$];

   logic          n_ld = 1'b1, n_wr = 1'b0, n_rf = 1'b0;
   logic [RW-1:0] n_row = '0, n_rfr = '0;
   logic [CW-1:0] n_col = '0;
   logic [BW-1:0] n_bank = '0;
   logic [NG-1:0] n_en = '1;

   always #4 clk = ~clk;

   dram_addr_steer #(.ROW_W(RW), .COL_W(CW), .BANK_W(BW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_load_n(cfg_load_n), .row_in(row_in),
      .col_in(col_in), .bank_in(bank_in), .cas_en(cas_en), .wr_in(wr_in),
      .acc_req(acc_req), .col_inc(col_inc), .rfsh_active(rfsh_active),
      .rfsh_row(rfsh_row), .dram_addr(dram_addr), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n)
   );

   task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic acc, input logic inc, input logic [NG-1:0] eras,
                       input logic [NG-1:0] ecas, input logic [RW-1:0] eaddr,
                       input logic ewe, input string tag);
      exp_t e;
      @(negedge clk);
      acc_req = acc; col_inc = inc; cfg_load_n = n_ld; wr_in = n_wr;
      row_in = n_row; col_in = n_col; bank_in = n_bank; cas_en = n_en;
      rfsh_active = n_rf; rfsh_row = n_rfr;
      e.ras = eras; e.cas = ecas; e.addr = eaddr; e.we = ewe; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.tag, "ras_n", 32'(ras_n), 32'(e.ras));
            cmp(e.tag, "cas_n", 32'(cas_n), 32'(e.cas));
            cmp(e.tag, "dram_addr", 32'(dram_addr), 32'(e.addr));
            cmp(e.tag, "we_n", 32'(we_n), 32'(e.we));
         end
      end
   end

   initial begin : watchdog
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      cmp("R8 reset", "ras_n", 32'(ras_n), 32'hF);
      cmp("R8 reset", "cas_n", 32'(cas_n), 32'hF);
      cmp("R8 reset", "we_n", 32'(we_n), 32'h1);
      cmp("R8 reset", "dram_addr", 32'(dram_addr), 32'h0);

      // R1 R4 read access, default map (all groups), then lane toggling R5
      n_row = 10'h155; n_col = 10'h2AA; n_bank = 2'd2; n_wr = 1'b0; n_en = 4'hF;
      step(1, 0, 4'h0, 4'hF, 10'h155, 1, "R1 row cycle");
      step(1, 0, 4'h0, 4'hF, 10'h2AA, 1, "R1 column cycle");
      step(1, 0, 4'h0, 4'h0, 10'h2AA, 1, "R1 cas cycle R4 all groups");
      n_en = 4'b0101;
      step(1, 0, 4'h0, 4'b1010, 10'h2AA, 1, "R5 lane toggle");
      step(0, 0, 4'hF, 4'hF, 10'h2AA, 1, "R8 end of access");
      step(0, 0, 4'hF, 4'hF, 10'h2AA, 1, "R8 idle hold");

      // R3 load: single-group map, write delay on, remap 01; request ignored
      n_ld = 1'b0; n_row = 10'h002; n_col = 10'h100; n_bank = 2'd1; n_en = 4'hF;
      step(1, 0, 4'hF, 4'hF, 10'h2AA, 1, "R3 no start during load");
      n_ld = 1'b1;
      step(0, 0, 4'hF, 4'hF, 10'h2AA, 1, "R3 load idle");

      // R7 R9 R4 write with delay, bank 2 ^ 1 = group 3
      n_row = 10'h0F0; n_col = 10'h00F; n_bank = 2'd2; n_wr = 1'b1;
      step(1, 0, 4'b0111, 4'hF, 10'h0F0, 0, "R9 write row R4 single");
      step(1, 0, 4'b0111, 4'hF, 10'h00F, 0, "R7 column cycle");
      step(1, 0, 4'b0111, 4'hF, 10'h00F, 0, "R7 delayed cycle");
      step(1, 0, 4'b0111, 4'b0111, 10'h00F, 0, "R7 cas after delay");
      step(0, 0, 4'hF, 4'hF, 10'h00F, 1, "R9 write end");

      // R7 read not delayed, R6 wrap and refresh freeze; bank 0 ^ 1 = group 1
      n_row = 10'h3C3; n_col = 10'h3FF; n_bank = 2'd0; n_wr = 1'b0;
      step(1, 0, 4'b1101, 4'hF, 10'h3C3, 1, "R7 read row");
      step(1, 0, 4'b1101, 4'hF, 10'h3FF, 1, "R7 read column");
      step(1, 0, 4'b1101, 4'b1101, 10'h3FF, 1, "R7 read cas not delayed");
      step(1, 1, 4'b1101, 4'b1101, 10'h000, 1, "R6 increment wraps");
      n_rf = 1'b1; n_rfr = 10'h0AB;
      step(1, 1, 4'b1101, 4'b1101, 10'h0AB, 1, "R2 refresh overrides bus");
      n_rf = 1'b0;
      step(1, 0, 4'b1101, 4'b1101, 10'h000, 1, "R6 no increment under refresh");
      step(1, 1, 4'b1101, 4'b1101, 10'h001, 1, "R6 increment again");
      step(0, 0, 4'hF, 4'hF, 10'h001, 1, "R8 burst end hold");

      // R3 top bits excluded: pair map, delay bit clear, remap 0
      n_ld = 1'b0; n_row = 10'h201; n_col = 10'h200; n_bank = 2'd0;
      step(0, 0, 4'hF, 4'hF, 10'h001, 1, "R3 reload");
      n_ld = 1'b1;
      n_row = 10'h011; n_col = 10'h022; n_bank = 2'd2; n_wr = 1'b1; n_en = 4'b0100;
      step(1, 0, 4'b0011, 4'hF, 10'h011, 0, "R4 pair upper half");
      step(1, 0, 4'b0011, 4'hF, 10'h022, 0, "R3 column");
      step(1, 0, 4'b0011, 4'b1011, 10'h022, 0, "R3 top column bit no delay R5");
      step(0, 0, 4'hF, 4'hF, 10'h022, 1, "R8 end");

      // R2 refresh in idle blocks a request
      n_rf = 1'b1; n_rfr = 10'h123; n_wr = 1'b0; n_en = 4'hF;
      step(1, 0, 4'hF, 4'hF, 10'h123, 1, "R2 refresh row, no start");
      n_rf = 1'b0;
      step(0, 0, 4'hF, 4'hF, 10'h123, 1, "R8 hold after refresh");

      @(negedge clk);
      acc_req = 1'b0;
      @(posedge clk);
      #3;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule